// File: doc/BRIEF.md
# Hall Commutation Decoder with Safe Direction Reversal

This block converts three Hall-effect rotor position inputs and a rotation direction request into six gate-drive commands for a three-phase bridge. The low-side commands are active high and the high-side commands are active low. The analog front end has already resolved comparator results, and they reach the block as single-bit inputs: motor-is-slow, undervoltage, peak current, coast/overvoltage and PWM-off.

Direction changes are guarded in two ways. A holding register accepts a new request only while the motor is flagged as slow. The accepted value then moves through a short shift chain that advances only on PWM clock ticks. While any part of that path disagrees with the request, every drive is blanked. The motor therefore coasts, and no reversal can reach the bridge sooner than one full PWM period.

On top of the commutation pattern, the block applies PWM chopping. In two-quadrant mode only the low side is chopped. In four-quadrant mode every active driver is chopped. Brake mode shorts the windings through the low side. Fault inputs shut the bridge off.

Top module: `bldc_commutator`

## Requirements
- R1: Hall codes 000 and 111 (hall_i[2]=H1, hall_i[1]=H2, hall_i[0]=H3) outside brake give lo_drv_o=000 and hi_drv_n_o=111.
- R2: For a valid Hall code with no blanking, fault or chop, exactly one lo_drv_o bit is 1 and exactly one hi_drv_n_o bit is 0. Bit 0 is phase A, bit 1 is phase B and bit 2 is phase C. The two active bits never belong to the same phase.
- R3: With effective direction 1, the code-to-(low-side, high-side) mapping is: 001→(B,C), 011→(A,C), 010→(A,B), 110→(C,B), 100→(C,A), 101→(B,A).
- R4: With effective direction 0, each valid code swaps the two phases: 001→(C,B), 011→(C,A), 010→(B,A), 110→(B,C), 100→(A,C), 101→(A,B).
- R5: The accepted direction loads dir_req_i on a clock edge only while speed_low_i is 1. Otherwise it holds, so a request that is withdrawn before speed_low_i rises leaves the old direction in force.
- R6: An accepted direction reaches the decoder only after DIR_STAGES clock edges on which pwm_tick_i is 1. The default is 2.
- R7: While dir_req_i differs from the accepted direction, or any shift stage differs from the accepted direction, all drives are off. Brake is the exception.
- R8: In two-quadrant mode (quad4_i=0), pwm_off_i forces lo_drv_o to 000 and leaves the decoded high-side command active.
- R9: In four-quadrant mode (quad4_i=1), pwm_off_i forces lo_drv_o=000 and hi_drv_n_o=111.
- R10: With brake_i=1, hi_drv_n_o=111 and lo_drv_o=111 regardless of the Hall code, quad4_i and direction blanking.
- R11: During brake, each of uv_fault_i, peak_fault_i, coast_i and pwm_off_i forces lo_drv_o to 000.
- R12: Outside brake, any of uv_fault_i, peak_fault_i or coast_i turns all drives off.
- R13: While rst_n is 0, all drives are off. After reset, the direction path is settled with direction 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwm_tick_i | input | 1 | One-cycle pulse per PWM period; advances the direction chain |
| hall_i | input | 3 | Hall inputs, bit 2 = H1, bit 0 = H3 |
| dir_req_i | input | 1 | Requested rotation direction |
| speed_low_i | input | 1 | Motor slow enough to accept a reversal |
| quad4_i | input | 1 | 1 = four-quadrant chopping, 0 = two-quadrant |
| brake_i | input | 1 | Brake mode request |
| pwm_off_i | input | 1 | PWM comparator off phase |
| uv_fault_i | input | 1 | Supply undervoltage |
| peak_fault_i | input | 1 | Peak current exceeded |
| coast_i | input | 1 | Coast / overvoltage command |
| lo_drv_o | output | 3 | Low-side commands, active high, bit 0 = phase A |
| hi_drv_n_o | output | 3 | High-side commands, active low, bit 0 = phase A |

## Verification
Some properties hold on every cycle and are checked by assertions:
- the accepted direction and the shift chain stay frozen without their enables;
- no phase ever has both its drivers on;
- the high side is off in brake;
- blanking and faults leave the bridge dark.

The exact mapping of all 16 code/direction pairs can only be shown by the bench's sweeps, and the same is true of the chopping results in both quadrant modes. The count of PWM ticks needed before a reversal takes effect, and the fact that a withdrawn request leaves the old direction in place, are also shown only by the bench.

// File: rtl/bldc_comm_pkg.sv
package bldc_comm_pkg;
   localparam int unsigned NUM_PHASES = 3;
   localparam int unsigned PH_A = 0;
   localparam int unsigned PH_B = 1;
   localparam int unsigned PH_C = 2;

   typedef logic [NUM_PHASES-1:0] phase_vec_t;

   // Hall-code based on sensor order H1 (MSB) .. H3 (LSB)
   typedef enum logic [2:0] {
      HALL_NONE0 = 3'b000,
      HALL_S1    = 3'b001,
      HALL_S2    = 3'b011,
      HALL_S3    = 3'b010,
      HALL_S4    = 3'b110,
      HALL_S5    = 3'b100,
      HALL_S6    = 3'b101,
      HALL_NONE7 = 3'b111
   } hall_code_e;

   function automatic phase_vec_t phase_bit(input int unsigned idx);
      phase_vec_t v;
      v = '0;
      v[idx] = 1'b1;
      return v;
   endfunction
endpackage

// File: rtl/bldc_dir_path.sv
module bldc_dir_path #(
   parameter int unsigned DIR_STAGES = 2,
   parameter bit          RESET_DIR  = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pwm_tick_i,
   input  logic speed_low_i,
   input  logic dir_req_i,
   output logic dir_eff_o,
   output logic busy_o
);
   localparam int unsigned LAST = DIR_STAGES - 1;

   if (DIR_STAGES < 1) begin : g_bad_stages
      $error("bldc_dir_path: DIR_STAGES must be at least 1");
   end

   logic                  acc_dir_q;
   logic [DIR_STAGES-1:0] stg_q;
   logic                  chain_settled;

   // speed-gated holding register for the requested direction
   always_ff @(posedge clk) begin
      if (!rst_n)
         acc_dir_q <= RESET_DIR;
      else if (speed_low_i)
         acc_dir_q <= dir_req_i;
   end

   for (genvar g = 0; g < DIR_STAGES; g++) begin : g_stage
      logic stg_d;
      if (g == 0) begin : g_head
         assign stg_d = acc_dir_q;
      end else begin : g_body
         assign stg_d = stg_q[g-1];
      end
      always_ff @(posedge clk) begin
         if (!rst_n)
            stg_q[g] <= RESET_DIR;
         else if (pwm_tick_i)
            stg_q[g] <= stg_d;
      end
   end

   assign chain_settled = (stg_q == {DIR_STAGES{acc_dir_q}});
   assign busy_o        = (dir_req_i != acc_dir_q) || !chain_settled;
   assign dir_eff_o     = stg_q[LAST];

   AST_ACC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !speed_low_i |=> $stable(acc_dir_q)); // R5
   AST_CHAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !pwm_tick_i |=> $stable(stg_q)); // R6
   AST_EFF_MOVES_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      (dir_eff_o != $past(dir_eff_o)) |-> $past(pwm_tick_i)); // R6
endmodule

// File: rtl/bldc_hall_decode.sv
module bldc_hall_decode
   import bldc_comm_pkg::*;
#(
   parameter int unsigned PHASES = 3
) (
   input  logic [2:0]        hall_i,
   input  logic              dir_i,
   output logic [PHASES-1:0] lo_sel_o,
   output logic [PHASES-1:0] hi_sel_o
);
   if (PHASES != NUM_PHASES) begin : g_bad_phases
      $error("bldc_hall_decode: only three phases are supported");
   end

   phase_vec_t fwd_lo, fwd_hi;

   // forward sequence; reverse swaps the two selected phases
   always_comb begin
      fwd_lo = '0;
      fwd_hi = '0;
      unique case (hall_code_e'(hall_i))
         HALL_S1: begin fwd_lo = phase_bit(PH_B); fwd_hi = phase_bit(PH_C); end
         HALL_S2: begin fwd_lo = phase_bit(PH_A); fwd_hi = phase_bit(PH_C); end
         HALL_S3: begin fwd_lo = phase_bit(PH_A); fwd_hi = phase_bit(PH_B); end
         HALL_S4: begin fwd_lo = phase_bit(PH_C); fwd_hi = phase_bit(PH_B); end
         HALL_S5: begin fwd_lo = phase_bit(PH_C); fwd_hi = phase_bit(PH_A); end
         HALL_S6: begin fwd_lo = phase_bit(PH_B); fwd_hi = phase_bit(PH_A); end
         default: begin fwd_lo = '0;              fwd_hi = '0;              end
      endcase
   end

   assign lo_sel_o = dir_i ? fwd_lo : fwd_hi;
   assign hi_sel_o = dir_i ? fwd_hi : fwd_lo;
endmodule

// File: rtl/bldc_drive_gate.sv
module bldc_drive_gate #(
   parameter int unsigned PHASES = 3
) (
   input  logic              run_en_i,
   input  logic [PHASES-1:0] lo_sel_i,
   input  logic [PHASES-1:0] hi_sel_i,
   input  logic              busy_i,
   input  logic              brake_i,
   input  logic              quad4_i,
   input  logic              pwm_off_i,
   input  logic              fault_i,
   output logic [PHASES-1:0] lo_drv_o,
   output logic [PHASES-1:0] hi_drv_n_o
);
   if (PHASES < 1) begin : g_bad_phases
      $error("bldc_drive_gate: PHASES must be positive");
   end

   logic allow_any;
   logic allow_run;
   logic lo_chop;
   logic hi_chop;

   assign allow_any = run_en_i && !fault_i;
   assign allow_run = allow_any && !brake_i && !busy_i;
   assign lo_chop   = pwm_off_i;
   assign hi_chop   = pwm_off_i && quad4_i;

   for (genvar p = 0; p < PHASES; p++) begin : g_phase
      logic lo_on, hi_on;
      always_comb begin
         if (brake_i)
            lo_on = allow_any && !lo_chop;
         else
            lo_on = allow_run && lo_sel_i[p] && !lo_chop;
         hi_on = allow_run && hi_sel_i[p] && !hi_chop;
      end
      assign lo_drv_o[p]   = lo_on;
      assign hi_drv_n_o[p] = !hi_on;
   end
endmodule

// File: rtl/bldc_commutator.sv
module bldc_commutator
   import bldc_comm_pkg::*;
#(
   parameter int unsigned DIR_STAGES = 2,
   parameter bit          RESET_DIR  = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pwm_tick_i,
   input  logic [2:0] hall_i,
   input  logic       dir_req_i,
   input  logic       speed_low_i,
   input  logic       quad4_i,
   input  logic       brake_i,
   input  logic       pwm_off_i,
   input  logic       uv_fault_i,
   input  logic       peak_fault_i,
   input  logic       coast_i,
   output logic [2:0] lo_drv_o,
   output logic [2:0] hi_drv_n_o
);
   logic       dir_eff;
   logic       dir_busy;
   logic       fault_any;
   phase_vec_t lo_sel, hi_sel;

   assign fault_any = uv_fault_i || peak_fault_i || coast_i;

   bldc_dir_path #(
      .DIR_STAGES (DIR_STAGES),
      .RESET_DIR  (RESET_DIR)
   ) u_dir (
      .clk         (clk),
      .rst_n       (rst_n),
      .pwm_tick_i  (pwm_tick_i),
      .speed_low_i (speed_low_i),
      .dir_req_i   (dir_req_i),
      .dir_eff_o   (dir_eff),
      .busy_o      (dir_busy)
   );

   bldc_hall_decode #(.PHASES(NUM_PHASES)) u_dec (
      .hall_i   (hall_i),
      .dir_i    (dir_eff),
      .lo_sel_o (lo_sel),
      .hi_sel_o (hi_sel)
   );

   bldc_drive_gate #(.PHASES(NUM_PHASES)) u_gate (
      .run_en_i   (rst_n),
      .lo_sel_i   (lo_sel),
      .hi_sel_i   (hi_sel),
      .busy_i     (dir_busy),
      .brake_i    (brake_i),
      .quad4_i    (quad4_i),
      .pwm_off_i  (pwm_off_i),
      .fault_i    (fault_any),
      .lo_drv_o   (lo_drv_o),
      .hi_drv_n_o (hi_drv_n_o)
   );

   AST_NO_SHOOT_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
      (lo_drv_o & ~hi_drv_n_o) == 3'b000); // R2
   AST_ONE_LOW_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
      !brake_i |-> $onehot0(lo_drv_o)); // R2
   AST_ONE_HIGH_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~hi_drv_n_o)); // R2
   AST_BLANK_ON_REVERSAL: assert property (@(posedge clk) disable iff (!rst_n)
      (dir_busy && !brake_i) |-> (lo_drv_o == 3'b000 && hi_drv_n_o == 3'b111)); // R7
   AST_BRAKE_HIGH_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      brake_i |-> hi_drv_n_o == 3'b111); // R10
   AST_FAULT_DARK: assert property (@(posedge clk) disable iff (!rst_n)
      fault_any |-> (lo_drv_o == 3'b000 && hi_drv_n_o == 3'b111)); // R12
   AST_TWO_QUAD_HIGH_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (!quad4_i && pwm_off_i && !brake_i && !fault_any && !dir_busy &&
       hall_i != 3'b000 && hall_i != 3'b111) |-> $countones(~hi_drv_n_o) == 1); // R8
endmodule

// File: tb/bldc_commutator_tb.sv
`timescale 1ns/1ps
module bldc_commutator_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pwm_tick_i = 1'b0;
   logic [2:0] hall_i = 3'b001;
   logic       dir_req_i = 1'b1;
   logic       speed_low_i = 1'b0;
   logic       quad4_i = 1'b0;
   logic       brake_i = 1'b0;
   logic       pwm_off_i = 1'b0;
   logic       uv_fault_i = 1'b0;
   logic       peak_fault_i = 1'b0;
   logic       coast_i = 1'b0;
   logic [2:0] lo_drv_o, hi_drv_n_o;

   int n_vec = 0;
   int n_bad = 0;
   int cycles = 0;
   bit done = 0;

   always #2 clk = ~clk; // 250 MHz

   bldc_commutator u_dut (
      .clk(clk), .rst_n(rst_n), .pwm_tick_i(pwm_tick_i), .hall_i(hall_i),
      .dir_req_i(dir_req_i), .speed_low_i(speed_low_i), .quad4_i(quad4_i),
      .brake_i(brake_i), .pwm_off_i(pwm_off_i), .uv_fault_i(uv_fault_i),
      .peak_fault_i(peak_fault_i), .coast_i(coast_i),
      .lo_drv_o(lo_drv_o), .hi_drv_n_o(hi_drv_n_o)
   );

   // phase indices: 0 = A, 1 = B, 2 = C ; -1 = none
   function automatic int fwd_low(input logic [2:0] h);
      case (h)
         3'b001: return 1; 3'b011: return 0; 3'b010: return 0;
         3'b110: return 2; 3'b100: return 2; 3'b101: return 1;
         default: return -1;
      endcase
   endfunction
   function automatic int fwd_high(input logic [2:0] h);
      case (h)
         3'b001: return 2; 3'b011: return 2; 3'b010: return 1;
         3'b110: return 1; 3'b100: return 0; 3'b101: return 0;
         default: return -1;
      endcase
   endfunction
   function automatic int rev_low(input logic [2:0] h);
      case (h)
         3'b101: return 0; 3'b100: return 0; 3'b110: return 1;
         3'b010: return 1; 3'b011: return 2; 3'b001: return 2;
         default: return -1;
      endcase
   endfunction
   function automatic int rev_high(input logic [2:0] h);
      case (h)
         3'b101: return 1; 3'b100: return 2; 3'b110: return 2;
         3'b010: return 0; 3'b011: return 0; 3'b001: return 1;
         default: return -1;
      endcase
   endfunction

   function automatic logic [2:0] vec_of(input int idx);
      return (idx < 0) ? 3'b000 : 3'(1 << idx);
   endfunction

   // expected {hi_n, lo} for a settled direction path
   function automatic logic [5:0] model(input logic [2:0] h, input logic d,
         input logic brk, input logic q4, input logic poff, input logic flt);
      logic [2:0] lo, hi;
      if (flt) begin
         lo = 3'b000; hi = 3'b000;
      end else if (brk) begin
         lo = poff ? 3'b000 : 3'b111; hi = 3'b000;
      end else begin
         lo = vec_of(d ? fwd_low(h)  : rev_low(h));
         hi = vec_of(d ? fwd_high(h) : rev_high(h));
         if (poff) begin
            lo = 3'b000;
            if (q4) hi = 3'b000;
         end
      end
      return {~hi, lo};
   endfunction

   task automatic check(input string req, input logic [5:0] exp);
      #1;
      n_vec++;
      if ({hi_drv_n_o, lo_drv_o} !== exp) begin
         n_bad++;
         $display("FAIL %s hall=%b: got hi_n=%b lo=%b expected hi_n=%b lo=%b",
                  req, hall_i, hi_drv_n_o, lo_drv_o, exp[5:3], exp[2:0]);
      end
   endtask

   task automatic tick();
      @(negedge clk) pwm_tick_i = 1'b1;
      @(negedge clk) pwm_tick_i = 1'b0;
   endtask

   task automatic sweep_run(input logic d, input string tag);
      for (int h = 0; h < 8; h++)
         for (int m = 0; m < 4; m++) begin
            @(negedge clk);
            hall_i = 3'(h); quad4_i = m[1]; pwm_off_i = m[0];
            check(tag, model(3'(h), d, 1'b0, m[1], m[0], 1'b0));
         end
      pwm_off_i = 1'b0; quad4_i = 1'b0;
   endtask

   localparam logic [5:0] DARK = 6'b111_000;

   initial begin
      // R13: reset keeps bridge dark
      repeat (3) @(negedge clk);
      check("R13 reset dark", DARK);
      rst_n = 1'b1;
      @(negedge clk);
      check("R13 settled dir 1", model(3'b001, 1'b1, 0, 0, 0, 0));

      // R1 R2 R3 R8 R9: full sweep, direction 1
      sweep_run(1'b1, "R3 fwd sweep R1 R2 R8 R9");

      // R12: each fault darkens every valid code
      for (int f = 0; f < 3; f++)
         for (int h = 1; h < 7; h++) begin
            @(negedge clk);
            hall_i = 3'(h);
            uv_fault_i = (f == 0); peak_fault_i = (f == 1); coast_i = (f == 2);
            check("R12 fault off", DARK);
         end
      uv_fault_i = 0; peak_fault_i = 0; coast_i = 0;

      // R5/R7: request while fast is blanked but not accepted
      @(negedge clk) hall_i = 3'b011; dir_req_i = 1'b0;
      check("R7 request mismatch blank", DARK);
      tick(); tick(); tick();
      check("R7 still blanked while fast", DARK);
      @(negedge clk) dir_req_i = 1'b1;
      check("R5 old direction kept", model(3'b011, 1'b1, 0, 0, 0, 0));

      // R6/R7: accepted reversal waits for two PWM ticks
      @(negedge clk) speed_low_i = 1'b1; dir_req_i = 1'b0;
      @(negedge clk) speed_low_i = 1'b0;
      check("R7 accepted, chain unsettled", DARK);
      repeat (5) @(negedge clk);
      check("R6 no tick, no change", DARK);
      tick();
      check("R6 one tick still blank", DARK);
      tick();
      check("R6 two ticks reversed", model(3'b011, 1'b0, 0, 0, 0, 0));

      // R4: full sweep, direction 0
      sweep_run(1'b0, "R4 rev sweep");

      // R10 R11: brake sweep
      brake_i = 1'b1;
      for (int h = 0; h < 8; h++)
         for (int m = 0; m < 32; m++) begin
            logic flt;
            @(negedge clk);
            hall_i = 3'(h); quad4_i = m[0]; pwm_off_i = m[1];
            uv_fault_i = m[2]; peak_fault_i = m[3]; coast_i = m[4];
            flt = m[2] | m[3] | m[4];
            check((flt | m[1]) ? "R11 brake gated" : "R10 brake",
                  model(3'(h), 1'b0, 1'b1, m[0], m[1], flt));
         end
      uv_fault_i = 0; peak_fault_i = 0; coast_i = 0; pwm_off_i = 0; quad4_i = 0;

      // R10: brake overrides reversal blanking
      @(negedge clk) dir_req_i = 1'b1;
      check("R10 brake during blank", 6'b111_111);
      @(negedge clk) brake_i = 1'b0;
      check("R7 blank after brake off", DARK);

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000 && !done) begin
         n_bad++;
         $display("FAIL watchdog: got %0d cycles expected completion", cycles);
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end
endmodule